// File: doc/BRIEF.md
# Dual-Clock FIFO with Width-Splitting Read Port

This block is a first-in first-out buffer that holds 64 entries of 36 bits and moves data between two unrelated clock domains. A producer on the write clock stores whole 36-bit long words. A consumer on the read clock takes each long word out whole, as two 18-bit halves, or as four 9-bit bytes. The consumer picks the piece width on every read through a two-bit size code.

Each domain has its own status flags. The write side has an active-low full flag. The read side has an active-low empty flag and an active-low almost-empty flag. Each side keeps a binary pointer and publishes it in Gray code. The other domain takes that pointer in through a two-stage synchronizer, so a flag reacts to activity on the far side after a fixed number of cycles of the receiving clock. A long word stays stored until its final piece has been read. Only then does the read pointer move, and only then can the flags respond.

Top module: `bm_async_fifo`

## Requirements
- R1: Long words leave the FIFO in the order they were accepted, with all 36 bits intact, and up to 64 of them can be held at once.
- R2: A write is accepted on a rising write-clock edge only when wa_sel_n is 0, wa_dir is 1, wa_mbox is 0, wa_en is 1 and wa_full_n is 1. Any other combination stores nothing.
- R3: A read is attempted on a rising read-clock edge only when rb_sel_n is 0, rb_dir is 0, rb_en is 1 and rb_size is not 2'b11. Any other combination leaves rb_data and the FIFO contents unchanged.
- R4: rb_size 2'b00 returns the whole entry. rb_size 2'b01 returns an 18-bit half in rb_data[17:0], with bits [35:18] of the entry first and then bits [17:0]. rb_size 2'b10 returns a 9-bit byte in rb_data[8:0], from bits [35:27] down to bits [8:0]. Unused upper bits of rb_data are 0.
- R5: Each entry has a byte offset that starts at 0. A byte read adds 1 to it and a word read adds 2. The entry is released, and the flags may change, only when the offset reaches 4 or on any long read, which always returns the whole entry. A word read at offset 0 or 1 returns the upper half.
- R6: rb_empty_n is 0 whenever the read side sees no stored entry. After a write into an empty FIFO, it rises on the third read-clock edge after the write edge, or on the fourth if the two edges are close together.
- R7: rb_aempty_n is 0 whenever the read-side occupancy, counted in long words, is at or below AE_X (default 8). It is 1 when the occupancy is above AE_X.
- R8: wa_full_n is 0 while 64 entries are held, and writes are then ignored. After a read releases an entry, wa_full_n returns to 1 within three to four write-clock edges, and the next write is then accepted.
- R9: A read attempted while rb_empty_n is 0 changes neither rb_data nor the read pointer.
- R10: rb_data is a register that changes only on an accepted read. Between reads it holds the last piece delivered.
- R11: Synchronous active-high resets clear each domain: rb_data 0, rb_empty_n 0 and rb_aempty_n 0 under rst_b, and wa_full_n 1 under rst_a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| rst_a | input | 1 | Synchronous active-high reset, write side |
| wa_sel_n | input | 1 | Write-side select, active low |
| wa_dir | input | 1 | Write-side direction, 1 = write |
| wa_mbox | input | 1 | Side-path select, must be 0 for a FIFO write |
| wa_en | input | 1 | Write-side enable |
| wa_data | input | 36 | Long word to store |
| wa_full_n | output | 1 | Full flag, active low |
| clk_b | input | 1 | Read-side clock |
| rst_b | input | 1 | Synchronous active-high reset, read side |
| rb_sel_n | input | 1 | Read-side select, active low |
| rb_dir | input | 1 | Read-side direction, 0 = read |
| rb_en | input | 1 | Read-side enable |
| rb_size | input | 2 | Piece width: 00 long, 01 word, 10 byte, 11 no read |
| rb_data | output | 36 | Registered piece, right-aligned |
| rb_empty_n | output | 1 | Empty flag, active low |
| rb_aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The assertions assume that the two resets are asserted together and held long enough for each synchronizer to fill with zeros. They also assume that each domain sees only Gray-coded pointers that move by at most one step per source edge. As a result, the occupancy one side computes from the other side's pointer never exceeds the depth and never goes negative. The bench drives every input on the falling edge of its own clock and runs the two clocks at unrelated periods. It issues writes and reads only through the qualifier pins, so both pointers advance one entry at a time. The reference model checks each flag in its safe direction on every clock, and checks it exactly after idle stretches long enough for both synchronizers to settle.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_NONE = 2'b11
  } rd_size_e;

  localparam int unsigned BYTES_PER_ENTRY = 4;
  localparam int unsigned OFF_W = 3;
endpackage

// File: rtl/bmf_gray_sync.sv
module bmf_gray_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/bmf_mem.sv
module bmf_mem #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/bmf_wr_ctrl.sv
module bmf_wr_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [PW-1:0] rd_gray_s,
  output logic          wr_go,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wr_gray,
  output logic          full_n
);
  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wr_bin, wr_bin_nxt, wr_gray_nxt, full_cmp;

  assign wr_go       = wr_req && full_n;
  assign wr_bin_nxt  = wr_bin + PW'(wr_go);
  assign wr_gray_nxt = b2g(wr_bin_nxt);
  assign full_cmp    = {~rd_gray_s[PW-1:PW-2], rd_gray_s[PW-3:0]};
  assign waddr       = wr_bin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      full_n  <= 1'b1;
    end else begin
      wr_bin  <= wr_bin_nxt;
      wr_gray <= wr_gray_nxt;
      full_n  <= (wr_gray_nxt != full_cmp);
    end
  end

  logic [PW-1:0] occ_seen;
  assign occ_seen = wr_bin - g2b(rd_gray_s);

  // R8: occupancy seen from the write side never exceeds the depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    occ_seen <= PW'(DEPTH));

  // R8: a full store always shows the full flag
  assert_full_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (occ_seen == PW'(DEPTH)) |-> !full_n);
endmodule

// File: rtl/bmf_rd_ctrl.sv
module bmf_rd_ctrl
  import bmf_pkg::*;
#(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AE_X  = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1,
  localparam int unsigned BW   = WIDTH / BYTES_PER_ENTRY,
  localparam int unsigned HW   = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  rd_size_e         size,
  input  logic [PW-1:0]    wr_gray_s,
  input  logic [WIDTH-1:0] q,
  output logic [AW-1:0]    raddr,
  output logic [PW-1:0]    rd_gray,
  output logic             empty_n,
  output logic             aempty_n,
  output logic [WIDTH-1:0] dout
);
  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0]    rd_bin, rd_bin_nxt, wbin_s, occ_nxt;
  logic [OFF_W-1:0] off, off_sum, step;
  logic             rd_go, last;
  logic [WIDTH-1:0] piece, shifted;

  assign rd_go  = rd_req && empty_n;
  assign wbin_s = g2b(wr_gray_s);
  assign raddr  = rd_bin[AW-1:0];

  always_comb begin
    unique case (size)
      SZ_WORD: step = OFF_W'(2);
      SZ_BYTE: step = OFF_W'(1);
      default: step = OFF_W'(BYTES_PER_ENTRY);
    endcase
  end

  assign off_sum    = off + step;
  assign last       = (size == SZ_LONG) || (off_sum >= OFF_W'(BYTES_PER_ENTRY));
  assign rd_bin_nxt = rd_bin + PW'(rd_go && last);
  assign occ_nxt    = wbin_s - rd_bin_nxt;

  always_comb begin
    shifted = '0;
    piece   = q;
    unique case (size)
      SZ_WORD: begin
        shifted = (off < OFF_W'(2)) ? (q >> HW) : q;
        piece   = {{(WIDTH-HW){1'b0}}, shifted[HW-1:0]};
      end
      SZ_BYTE: begin
        shifted = q >> (BW * (BYTES_PER_ENTRY - 1 - 32'(off)));
        piece   = {{(WIDTH-BW){1'b0}}, shifted[BW-1:0]};
      end
      default: piece = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bin   <= '0;
      rd_gray  <= '0;
      off      <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      dout     <= '0;
    end else begin
      rd_bin   <= rd_bin_nxt;
      rd_gray  <= b2g(rd_bin_nxt);
      empty_n  <= (occ_nxt != '0);
      aempty_n <= (occ_nxt > PW'(AE_X));
      if (rd_go) begin
        dout <= piece;
        off  <= last ? '0 : off_sum;
      end
    end
  end

  // R6: no entry visible means the empty flag is asserted
  assert_empty_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (wbin_s == rd_bin) |-> !empty_n);

  // R6: the read pointer never passes the synchronized write pointer
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    (wbin_s - rd_bin) <= PW'(DEPTH));

  // R7: leaving almost-empty implies leaving empty
  assert_aempty_order_R7: assert property (@(posedge clk) disable iff (rst)
    aempty_n |-> empty_n);

  // R9: a read attempted while empty leaves the output register alone
  assert_ignored_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !empty_n) |=> $stable(dout));

  // R5: the byte offset is back to zero whenever the pointer moves
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_bin != $past(rd_bin)) |-> (off == '0));
endmodule

// File: rtl/bm_async_fifo.sv
module bm_async_fifo
  import bmf_pkg::*;
#(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AE_X  = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             clk_a,
  input  logic             rst_a,
  input  logic             wa_sel_n,
  input  logic             wa_dir,
  input  logic             wa_mbox,
  input  logic             wa_en,
  input  logic [WIDTH-1:0] wa_data,
  output logic             wa_full_n,
  input  logic             clk_b,
  input  logic             rst_b,
  input  logic             rb_sel_n,
  input  logic             rb_dir,
  input  logic             rb_en,
  input  logic [1:0]       rb_size,
  output logic [WIDTH-1:0] rb_data,
  output logic             rb_empty_n,
  output logic             rb_aempty_n
);
  logic          wr_req, wr_go, rd_req;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  logic [WIDTH-1:0] mem_q;
  rd_size_e      size;

  assign wr_req = !wa_sel_n && wa_dir && !wa_mbox && wa_en;
  assign size   = rd_size_e'(rb_size);
  assign rd_req = !rb_sel_n && !rb_dir && rb_en && (size != SZ_NONE);

  bmf_wr_ctrl #(.DEPTH(DEPTH)) i_wr (
    .clk(clk_a), .rst(rst_a), .wr_req(wr_req), .rd_gray_s(rd_gray_s),
    .wr_go(wr_go), .waddr(waddr), .wr_gray(wr_gray), .full_n(wa_full_n)
  );

  bmf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_mem (
    .clk(clk_a), .we(wr_go), .waddr(waddr), .wdata(wa_data),
    .raddr(raddr), .rdata(mem_q)
  );

  bmf_gray_sync #(.WIDTH(PW)) i_w2r (
    .clk(clk_b), .rst(rst_b), .d(wr_gray), .q(wr_gray_s)
  );

  bmf_gray_sync #(.WIDTH(PW)) i_r2w (
    .clk(clk_a), .rst(rst_a), .d(rd_gray), .q(rd_gray_s)
  );

  bmf_rd_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AE_X(AE_X)) i_rd (
    .clk(clk_b), .rst(rst_b), .rd_req(rd_req), .size(size),
    .wr_gray_s(wr_gray_s), .q(mem_q), .raddr(raddr), .rd_gray(rd_gray),
    .empty_n(rb_empty_n), .aempty_n(rb_aempty_n), .dout(rb_data)
  );

  // R2: a disqualified write request never changes the published pointer
  assert_wr_qual_R2: assert property (@(posedge clk_a) disable iff (rst_a)
    !wr_req |=> $stable(wr_gray));

  // R3: a disqualified read request never changes the output register
  assert_rd_qual_R3: assert property (@(posedge clk_b) disable iff (rst_b)
    !rd_req |=> $stable(rb_data));
endmodule

// File: tb/test_bm_async_fifo.sv
module test_bm_async_fifo;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int AE_X  = 8;
  localparam int DEPTH = 64;

  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic wa_sel_n = 1, wa_dir = 0, wa_mbox = 0, wa_en = 0;
  logic [35:0] wa_data = '0;
  logic wa_full_n;
  logic rb_sel_n = 1, rb_dir = 1, rb_en = 0;
  logic [1:0] rb_size = 2'b00;
  logic [35:0] rb_data;
  logic rb_empty_n, rb_aempty_n;

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  bm_async_fifo #(.AE_X(AE_X)) i_bm_async_fifo (
    .clk_a(clk_a), .rst_a(rst_a), .wa_sel_n(wa_sel_n), .wa_dir(wa_dir),
    .wa_mbox(wa_mbox), .wa_en(wa_en), .wa_data(wa_data), .wa_full_n(wa_full_n),
    .clk_b(clk_b), .rst_b(rst_b), .rb_sel_n(rb_sel_n), .rb_dir(rb_dir),
    .rb_en(rb_en), .rb_size(rb_size), .rb_data(rb_data),
    .rb_empty_n(rb_empty_n), .rb_aempty_n(rb_aempty_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [35:0] model_q [$];
  int model_off = 0;
  logic [35:0] exp_b = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: write side accepts per qualifier and full flag
  always @(posedge clk_a) begin
    if (!rst_a && !wa_sel_n && wa_dir && !wa_mbox && wa_en && wa_full_n)
      model_q.push_back(wa_data);
  end

  // Reference model: read side piece selection and release
  always @(posedge clk_b) begin
    if (rst_b) begin
      exp_b = '0;
      model_off = 0;
    end else if (!rb_sel_n && !rb_dir && rb_en && rb_size != 2'b11 && rb_empty_n) begin
      if (model_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 read granted with no data actual=1 expected=0");
      end else begin
        logic [35:0] e;
        e = model_q[0];
        if (rb_size == 2'b00) begin
          exp_b = e;
          model_off = 4;
        end else if (rb_size == 2'b01) begin
          exp_b = (model_off < 2) ? {18'd0, e[35:18]} : {18'd0, e[17:0]};
          model_off += 2;
        end else begin
          exp_b = {27'd0, 9'((e >> (9 * (3 - model_off))) & 36'h1ff)};
          model_off += 1;
        end
        if (model_off >= 4) begin
          model_off = 0;
          void'(model_q.pop_front());
        end
      end
    end
  end

  // Per-clock comparison on the read side: data and safe-direction flags
  always @(negedge clk_b) begin
    if (!rst_b && !done) begin
      chk(rb_data == exp_b, "R4/R10 rb_data", rb_data, exp_b);
      if (rb_empty_n && model_q.size() == 0)
        chk(0, "R6 empty_n high with nothing stored", rb_empty_n, 0);
      if (rb_aempty_n && model_q.size() <= AE_X)
        chk(0, "R7 aempty_n high at low occupancy", model_q.size(), AE_X + 1);
    end
  end

  // Per-clock comparison on the write side
  always @(negedge clk_a) begin
    if (!rst_a && !done && wa_full_n && model_q.size() >= DEPTH)
      chk(0, "R8 full_n high with store full", model_q.size(), DEPTH - 1);
  end

  task automatic wr_raw(input logic sel_n, input logic dir, input logic mbox,
                        input logic en, input logic [35:0] d);
    @(negedge clk_a);
    wa_sel_n = sel_n; wa_dir = dir; wa_mbox = mbox; wa_en = en; wa_data = d;
    @(negedge clk_a);
    wa_sel_n = 1; wa_en = 0;
  endtask

  task automatic wr(input logic [35:0] d);
    wr_raw(0, 1, 0, 1, d);
  endtask

  task automatic rd_raw(input logic sel_n, input logic dir, input logic en,
                        input logic [1:0] sz);
    @(negedge clk_b);
    rb_sel_n = sel_n; rb_dir = dir; rb_en = en; rb_size = sz;
    @(negedge clk_b);
    rb_sel_n = 1; rb_en = 0;
  endtask

  task automatic rd(input logic [1:0] sz);
    rd_raw(0, 0, 1, sz);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk_b);
  endtask

  task automatic flags(input string tag);
    int n;
    settle();
    n = model_q.size();
    chk(rb_empty_n == (n != 0), {"R6 settled empty_n ", tag}, rb_empty_n, n != 0);
    chk(rb_aempty_n == (n > AE_X), {"R7 settled aempty_n ", tag}, rb_aempty_n, n > AE_X);
    chk(wa_full_n == (n < DEPTH), {"R8 settled full_n ", tag}, wa_full_n, n < DEPTH);
  endtask

  int cyc = 0;
  always @(posedge clk_a) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk_b);
    rst_a = 0; rst_b = 0;
    @(negedge clk_b);
    // R11 reset state
    chk(rb_data == 0, "R11 rb_data reset", rb_data, 0);
    chk(rb_empty_n == 0, "R11 empty_n reset", rb_empty_n, 0);
    chk(rb_aempty_n == 0, "R11 aempty_n reset", rb_aempty_n, 0);
    chk(wa_full_n == 1, "R11 full_n reset", wa_full_n, 1);

    // R9: read while empty leaves rb_data alone (monitor compares)
    rd(2'b00);
    flags("empty");

    // R2: disqualified writes store nothing
    wr_raw(1, 1, 0, 1, 36'hbad000001);
    wr_raw(0, 0, 0, 1, 36'hbad000002);
    wr_raw(0, 1, 1, 1, 36'hbad000003);
    wr_raw(0, 1, 0, 0, 36'hbad000004);
    flags("R2 after disqualified writes");
    chk(model_q.size() == 0, "R2 nothing accepted", model_q.size(), 0);

    // R7 boundary: AE_X entries then one more
    for (int i = 0; i < AE_X; i++) wr(36'h123456789 + 36'(i * 36'h111111111));
    flags("R7 at AE_X");
    wr(36'hfedcba987);
    flags("R7 above AE_X");

    // R5: first word piece does not release the entry
    rd(2'b01);
    flags("R5 after first half");
    chk(rb_aempty_n == 1, "R5 aempty_n held mid entry", rb_aempty_n, 1);
    rd(2'b01);
    flags("R5 after second half");
    chk(rb_aempty_n == 0, "R5 aempty_n after release", rb_aempty_n, 0);

    // R4: byte pieces, then long
    for (int i = 0; i < 4; i++) rd(2'b10);
    rd(2'b00);
    // R5: mixed widths within one entry
    rd(2'b10); rd(2'b01); rd(2'b10);
    flags("R4 after byte and long reads");

    // R3: disqualified reads hold rb_data
    rd_raw(1, 0, 1, 2'b00);
    rd_raw(0, 1, 1, 2'b00);
    rd_raw(0, 0, 0, 2'b00);
    rd_raw(0, 0, 1, 2'b11);
    flags("R3 after disqualified reads");

    // R8: fill past full, extra writes ignored
    for (int i = 0; i < DEPTH + 6; i++) wr(36'(i) * 36'h010203051 + 36'h5);
    flags("R8 full");
    chk(model_q.size() == DEPTH, "R8 occupancy at full", model_q.size(), DEPTH);
    rd(2'b00);
    flags("R8 after one release");
    wr(36'h0aaaa5555);
    flags("R8 full again");

    // R1: concurrent traffic with random widths
    fork
      begin
        for (int i = 0; i < 200; i++) begin
          if ($urandom_range(1, 0) == 1) wr(36'($urandom) ^ 36'(i) << 32);
          else @(negedge clk_a);
        end
      end
      begin
        for (int i = 0; i < 160; i++) rd(2'($urandom_range(2, 0)));
      end
    join
    flags("R1 after mixed traffic");

    // R1: drain everything and read once more while empty (R9)
    for (int i = 0; i < 400 && model_q.size() > 0; i++) rd(2'b00);
    rd(2'b01);
    flags("R9 drained");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule